// File: doc/BRIEF.md
# Converter power-mode sequencer

This block holds the power-mode logic that sits on the converter side of a dual-channel serial ADC. It watches the conversion-start strobe, the serial clock and an active-low chip select. It then decides whether the device runs normally, sits in a light sleep with the reference still on, or sits in a deep sleep with the reference off. Every low interval on the conversion-start line is judged by how many serial-clock rising edges occur before the line returns high. A short-to-medium pulse asks for more sleep. A long pulse either wakes the device or, when it is already awake, starts a conversion.

All three inputs come from off-chip, so each passes through a two-flop synchroniser onto a free-running system clock before any edge is detected. The block drives a reference-enable, a reference-ready flag and an output-enable for the serial data pin. After a deep sleep, a settle counter on the system clock holds the ready flag low. The settle length is a parameter, so a bench can use a short value in place of the real 2 ms figure.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset the mode code is 00 (normal), the reference is enabled and ready, the data output is enabled and no conversion strobe is issued.
- R2: In normal mode, a conversion-start low pulse that returns high after at least 3 and fewer than 14 serial-clock rising edges moves the block to light sleep (mode 01). Reference-enable stays high, reference-ready stays high and the data output enable drops.
- R3: In light sleep, the same 3-to-13-edge pulse moves the block to deep sleep (mode 10). Reference-enable, reference-ready and data output enable are all low there.
- R4: In normal mode, a pulse of 14 or more edges gives exactly one single-cycle conversion strobe and leaves the mode at 00.
- R5: In normal mode, a pulse of fewer than 3 edges changes nothing and gives no strobe.
- R6: In either sleep mode, a pulse of fewer than 14 edges does not wake the block. A 3-to-13-edge pulse in deep sleep leaves it in deep sleep.
- R7: A pulse of 14 or more edges in light sleep returns the block to normal, with reference-ready high at once and no conversion strobe.
- R8: A pulse of 14 or more edges in deep sleep returns the block to normal with reference-enable high. Reference-ready stays low for SETTLE_CYC system-clock cycles and then rises.
- R9: While chip select is high the block behaves as in deep sleep (mode 10, all three enables low) and ignores conversion-start pulses. Driving chip select low returns it to normal and starts the R8 settle interval.
- R10: The edge boundaries are exact. 2 edges is short, 3 edges is a sleep request, 13 edges is a sleep request and 14 edges is long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnvst_i | input | 1 | Conversion-start line, idle high, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| cs_n_i | input | 1 | Active-low chip select, asynchronous |
| mode_o | output | 2 | Mode code: 00 normal, 01 light sleep, 10 deep sleep |
| ref_en_o | output | 1 | Reference enable |
| ref_rdy_o | output | 1 | Reference settled and usable |
| dout_oe_o | output | 1 | Serial data output enable (low means high impedance) |
| conv_start_o | output | 1 | One-cycle conversion-start strobe |

## Verification
The checker assumes that the serial clock and conversion-start line change far more slowly than the system clock. Each level must hold for several cycles, so no edge is lost in the synchronisers, and a serial-clock rise never lands in the same synchronised cycle as a conversion-start edge. The stimulus keeps every serial-clock phase and every gap around a conversion-start edge at four system-clock cycles. Chip select is toggled only while the conversion-start line is idle high, and it is held low through reset.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_LIGHT  = 2'b01,
    PM_DEEP   = 2'b10
  } pmode_e;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int              W      = 3,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/pwrseq_edge_cnt.sv
module pwrseq_edge_cnt #(
  parameter int SAT   = 14,
  localparam int CW   = $clog2(SAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          cnt_en_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  always_comb begin
    upd   = 1'b0;
    cnt_d = cnt_q;
    if (clr_i) begin
      upd   = 1'b1;
      cnt_d = '0;
    end else if (cnt_en_i && (cnt_q < CW'(SAT))) begin
      upd   = 1'b1;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwrseq_settle.sv
module pwrseq_settle #(
  parameter int SETTLE_CYC = 500000,
  localparam int TW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  logic [TW-1:0] tmr_q, tmr_d;
  logic          busy_q, busy_d;
  logic          upd;

  always_comb begin
    upd    = 1'b0;
    tmr_d  = tmr_q;
    busy_d = busy_q;
    if (start_i) begin
      upd    = 1'b1;
      tmr_d  = TW'(SETTLE_CYC - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      upd = 1'b1;
      if (tmr_q == '0) busy_d = 1'b0;
      else             tmr_d  = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      busy_q <= 1'b0;
    end else if (upd) begin
      tmr_q  <= tmr_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int SETTLE_CYC   = 500000,
  parameter int PD_MIN_EDGES = 3,
  parameter int WAKE_EDGES   = 14,
  parameter int SYNC_STAGES  = 2,
  localparam int CW          = $clog2(WAKE_EDGES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnvst_i,
  input  logic       sclk_i,
  input  logic       cs_n_i,
  output logic [1:0] mode_o,
  output logic       ref_en_o,
  output logic       ref_rdy_o,
  output logic       dout_oe_o,
  output logic       conv_start_o
);
  // bit order in the synchronised bundle: {cs_n, sclk, cnvst}
  localparam logic [2:0] IDLE_LVL = 3'b001;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  logic [2:0] pin_s, pin_prev;
  pwrseq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_i  ({cs_n_i, sclk_i, cnvst_i}),
    .q_o  (pin_s)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pin_prev <= IDLE_LVL;
    else             pin_prev <= pin_s;
  end

  logic cnvst_fall, cnvst_rise, sclk_rise, cs_high, cs_fall;
  assign cnvst_fall = pin_prev[0] & ~pin_s[0];
  assign cnvst_rise = ~pin_prev[0] & pin_s[0];
  assign sclk_rise  = ~pin_prev[1] & pin_s[1];
  assign cs_high    = pin_s[2];
  assign cs_fall    = pin_prev[2] & ~pin_s[2];

  logic [CW-1:0] edge_cnt;
  pwrseq_edge_cnt #(.SAT(WAKE_EDGES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (cnvst_fall),
    .cnt_en_i(sclk_rise & ~pin_s[0]),
    .cnt_o   (edge_cnt)
  );

  logic pulse_long, pulse_sleep;
  assign pulse_long  = (edge_cnt >= CW'(WAKE_EDGES));
  assign pulse_sleep = (edge_cnt >= CW'(PD_MIN_EDGES)) && !pulse_long;

  pmode_e state_q, state_d;
  logic   conv_q, conv_d;
  logic   settle_go;
  logic   settling;

  always_comb begin
    state_d   = state_q;
    conv_d    = 1'b0;
    settle_go = 1'b0;
    if (cs_high) begin
      state_d = PM_DEEP;
    end else if (cs_fall) begin
      state_d   = PM_NORMAL;
      settle_go = 1'b1;
    end else if (cnvst_rise) begin
      unique case (state_q)
        PM_NORMAL: begin
          if (pulse_long)       conv_d  = 1'b1;
          else if (pulse_sleep) state_d = PM_LIGHT;
        end
        PM_LIGHT: begin
          if (pulse_long)       state_d = PM_NORMAL;
          else if (pulse_sleep) state_d = PM_DEEP;
        end
        PM_DEEP: begin
          if (pulse_long) begin
            state_d   = PM_NORMAL;
            settle_go = 1'b1;
          end
        end
        default: state_d = PM_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= PM_NORMAL;
      conv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      conv_q  <= conv_d;
    end
  end

  pwrseq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start_i(settle_go),
    .busy_o (settling)
  );

  assign mode_o       = state_q;
  assign ref_en_o     = (state_q != PM_DEEP);
  assign ref_rdy_o    = (state_q != PM_DEEP) && !settling;
  assign dout_oe_o    = (state_q == PM_NORMAL);
  assign conv_start_o = conv_q;
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk #(
  parameter int SETTLE_CYC = 500000
) (
  input logic       clk,
  input logic       rst_ok,
  input logic       cs_n_i,
  input logic [1:0] mode_o,
  input logic       ref_en_o,
  input logic       ref_rdy_o,
  input logic       dout_oe_o,
  input logic       conv_start_o
);
  int   since_deep;
  logic seen_deep;
  int   up_cyc;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      since_deep <= 0;
      seen_deep  <= 1'b0;
      up_cyc     <= 0;
    end else begin
      if (up_cyc < 7) up_cyc <= up_cyc + 1;
      if (mode_o == 2'b10) begin
        seen_deep  <= 1'b1;
        since_deep <= 0;
      end else if (since_deep < SETTLE_CYC) begin
        since_deep <= since_deep + 1;
      end
    end
  end

  // R3
  deep_all_off_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_o == 2'b10) |-> (!ref_en_o && !ref_rdy_o && !dout_oe_o));

  // R2
  light_ref_on_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_o == 2'b01) |-> (ref_en_o && !dout_oe_o));

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    conv_start_o |=> !conv_start_o);

  // R4
  strobe_in_normal_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    conv_start_o |-> (mode_o == 2'b00 && dout_oe_o));

  // R8
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (seen_deep && since_deep < SETTLE_CYC) |-> !ref_rdy_o);

  // R9
  cs_forces_deep_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (up_cyc >= 4 && cs_n_i && $past(cs_n_i, 1) && $past(cs_n_i, 2) && $past(cs_n_i, 3))
      |-> (mode_o == 2'b10));

  // R1
  mode_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    mode_o != 2'b11);
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .cs_n_i      (cs_n_i),
  .mode_o      (mode_o),
  .ref_en_o    (ref_en_o),
  .ref_rdy_o   (ref_rdy_o),
  .dout_oe_o   (dout_oe_o),
  .conv_start_o(conv_start_o)
);

// File: tb/pwrseq_ctrl_bench.sv
`timescale 1ns/1ps
module pwrseq_ctrl_bench;
  localparam int SETTLE = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnvst, sclk, cs_n;
  logic [1:0] mode;
  logic       ref_en, ref_rdy, oe, conv;

  always #2 clk = ~clk;

  pwrseq_ctrl #(.SETTLE_CYC(SETTLE)) u_pwrseq_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnvst_i     (cnvst),
    .sclk_i      (sclk),
    .cs_n_i      (cs_n),
    .mode_o      (mode),
    .ref_en_o    (ref_en),
    .ref_rdy_o   (ref_rdy),
    .dout_oe_o   (oe),
    .conv_start_o(conv)
  );

  typedef struct {
    string      req;
    logic [1:0] mode;
    logic       en;
    logic       rdy;
    logic       oe;
    int         nconv;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  int   conv_seen = 0;
  bit   done = 1'b0;

  // monitor: counts strobes and compares against queued expectations
  always @(negedge clk) begin
    if (conv === 1'b1) conv_seen++;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (mode !== e.mode || ref_en !== e.en || ref_rdy !== e.rdy ||
          oe !== e.oe || conv_seen != e.nconv) begin
        n_errors++;
        $display("FAIL %s: got mode=%b en=%b rdy=%b oe=%b strobes=%0d, expected mode=%b en=%b rdy=%b oe=%b strobes=%0d",
                 e.req, mode, ref_en, ref_rdy, oe, conv_seen,
                 e.mode, e.en, e.rdy, e.oe, e.nconv);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_st(input string req, input logic [1:0] m, input logic en,
                           input logic rdy, input logic o, input int nc);
    exp_t e;
    e.req = req; e.mode = m; e.en = en; e.rdy = rdy; e.oe = o; e.nconv = nc;
    exp_q.push_back(e);
    wait_cyc(2);
  endtask

  task automatic pulse(input int edges);
    cnvst = 1'b0;
    wait_cyc(4);
    for (int i = 0; i < edges; i++) begin
      sclk = 1'b1; wait_cyc(4);
      sclk = 1'b0; wait_cyc(4);
    end
    cnvst = 1'b1;
    wait_cyc(12);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnvst = 1'b1; sclk = 1'b0; cs_n = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(6);
    expect_st("R1 reset state", 2'b00, 1, 1, 1, 0);

    pulse(2);  expect_st("R5 short pulse, R10 two edges", 2'b00, 1, 1, 1, 0);
    pulse(14); expect_st("R4 long pulse, R10 fourteen edges", 2'b00, 1, 1, 1, 1);
    pulse(20); expect_st("R4 second long pulse", 2'b00, 1, 1, 1, 2);
    pulse(3);  expect_st("R2 light sleep, R10 three edges", 2'b01, 1, 1, 0, 2);
    pulse(2);  expect_st("R6 short pulse in light sleep", 2'b01, 1, 1, 0, 2);
    pulse(13); expect_st("R3 deep sleep, R10 thirteen edges", 2'b10, 0, 0, 0, 2);
    pulse(5);  expect_st("R6 sleep request in deep sleep", 2'b10, 0, 0, 0, 2);
    pulse(13); expect_st("R6 thirteen edges in deep sleep", 2'b10, 0, 0, 0, 2);
    pulse(14); expect_st("R8 deep exit, still settling", 2'b00, 1, 0, 1, 2);
    wait_cyc(50);
    expect_st("R8 deep exit, settled", 2'b00, 1, 1, 1, 2);

    pulse(4);  expect_st("R2 light sleep again", 2'b01, 1, 1, 0, 2);
    pulse(14); expect_st("R7 light exit ready at once", 2'b00, 1, 1, 1, 2);
    pulse(16); expect_st("R4 strobe after light exit", 2'b00, 1, 1, 1, 3);

    cs_n = 1'b1; wait_cyc(10);
    expect_st("R9 chip select high", 2'b10, 0, 0, 0, 3);
    pulse(20); expect_st("R9 pulse ignored while deselected", 2'b10, 0, 0, 0, 3);
    cs_n = 1'b0; wait_cyc(10);
    expect_st("R9 reselect, settling", 2'b00, 1, 0, 1, 3);
    wait_cyc(50);
    expect_st("R9 reselect, settled", 2'b00, 1, 1, 1, 3);

    pulse(13); expect_st("R10 thirteen edges from normal", 2'b01, 1, 1, 0, 3);
    pulse(14); expect_st("R7 back to normal", 2'b00, 1, 1, 1, 3);

    wait_cyc(4);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule